// File: doc/BRIEF.md
# GPIO Bank Controller with Interrupt Detection

A register-programmed bank of general-purpose pins. Software chooses, per pin, whether the pin is a plain input, a driven output, or an interrupt source. It does this through a 32-bit register file. The register file uses one-cycle write and read strobes and word addresses. Output levels, direction and interrupt configuration are held in registers. Input pins are brought into the clock domain through a two-flop synchronizer.

For interrupt pins, a per-pin detector watches the synchronized level. Software chooses rising, falling or both-edge latching, or high or low level sensing. Latched status is removed by writing ones to a clear word. Interrupts are enabled through two words. Writing zeros to the mask word disables pins. Writing ones to the unmask word enables pins. Every enabled status bit is combined into a single host interrupt line. Read data is combinational while the read strobe is high, and zero otherwise.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every configuration word reads 0, `pin_oe` is 0, the enable word (word 6) reads 0 and `irq` is low.
- R2: Words 0 (interrupt mode, 1 = interrupt), 1 (direction, 1 = output), 2 (output level), 8 (polarity, 1 = active low / falling), 9 (trigger, 1 = edge, 0 = level) and 19 (1 = both edges) read back what was last written. `pin_out` always equals word 2.
- R3: `pin_oe` equals word 1 AND NOT word 0. Word 2 keeps its value whatever the direction.
- R4: Reading word 3 returns the word 2 bit for pins with `pin_oe` set. For all other pins it returns `pin_in` as it was two clock edges earlier.
- R5: Writing word 6 disables only the pins written as 0. Writing word 7 enables the pins written as 1. Word 6 reads 1 for enabled pins. Words 5 and 7 read 0.
- R6: An edge-mode interrupt pin latches its status bit (word 4) on a rising edge when its polarity bit is 0, and on a falling edge when it is 1. The bit stays set after the pin returns.
- R7: With the both-edge bit set, an edge-mode pin latches on any transition, whatever its polarity bit.
- R8: A level-mode interrupt pin shows status 1 while the synchronized input is high (polarity 0) or low (polarity 1), with no latching.
- R9: Writing 1s to word 5 clears the matching latched status bits, and 0 bits have no effect. An edge detected in the same cycle as its clear leaves the bit set.
- R10: A pin in general I/O mode never shows interrupt status.
- R11: Word 11 reads status AND enable. `irq` is high exactly when that value is nonzero.
- R12: Pins at or above the pin count read 0 in every word and never drive `pin_oe`. A pin count of 0, or one above 32, gives 32 pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | write strobe, one cycle per write |
| rd_en | input | 1 | read strobe |
| addr | input | 5 | word address |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data, combinational |
| pin_in | input | 32 | pin input levels (asynchronous) |
| pin_out | output | 32 | pin output levels |
| pin_oe | output | 32 | pin output enables |
| irq | output | 1 | combined host interrupt |

## Verification
The detector that latches an edge and the clear write aimed at the same status bit can meet on one clock edge. The bench provokes this by raising an edge-mode pin and counting the synchronizer stages, so that the clear strobe lands on the edge where the detection latches. The same write also clears a second bit that has no new edge. The contested bit must stay set, and the bit with no new edge must clear. Random register traffic and random pin levels are checked against shadow copies kept in bench functions.

// File: rtl/gpio_bank.sv
module gpio_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic act,
  input  logic edge_mode,
  input  logic pol,
  input  logic both,
  input  logic clr,
  output logic stat
);
  logic prev, latched, hit;

  assign hit = both ? (lvl ^ prev) : (pol ? (prev & ~lvl) : (lvl & ~prev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      latched <= 1'b0;
    end else begin
      prev <= lvl;
      if (!act || !edge_mode) latched <= 1'b0;
      else if (hit)           latched <= 1'b1;
      else if (clr)           latched <= 1'b0;
    end
  end

  assign stat = act & (edge_mode ? latched : (lvl ^ pol));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && edge_mode && hit) |=> latched);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && edge_mode && clr && !hit) |=> !latched);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !stat);
endmodule

module gpio_bank #(
  parameter int NPINS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic        irq
);
  localparam int NP = (NPINS < 1 || NPINS > 32) ? 32 : NPINS;
  localparam logic [31:0] VM = 32'((64'h1 << NP) - 64'h1);

  localparam logic [4:0] A_MODE = 5'd0, A_DIR = 5'd1, A_OUT = 5'd2, A_IN = 5'd3,
                         A_STAT = 5'd4, A_CLR = 5'd5, A_MASK = 5'd6, A_UNMASK = 5'd7,
                         A_POL = 5'd8, A_TRIG = 5'd9, A_PEND = 5'd11, A_BOTH = 5'd19;

  logic [31:0] mode_q, dir_q, out_q, pol_q, trig_q, both_q, en_q;
  logic [31:0] s1, s2, stat, clr_v, wd;

  assign wd = wdata & VM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; dir_q <= '0; out_q <= '0; pol_q <= '0;
      trig_q <= '0; both_q <= '0; en_q <= '0; s1 <= '0; s2 <= '0;
    end else begin
      s1 <= pin_in & VM;
      s2 <= s1;
      if (wr_en) begin
        case (addr)
          A_MODE:   mode_q <= wd;
          A_DIR:    dir_q  <= wd;
          A_OUT:    out_q  <= wd;
          A_POL:    pol_q  <= wd;
          A_TRIG:   trig_q <= wd;
          A_BOTH:   both_q <= wd;
          A_MASK:   en_q   <= en_q & wd;
          A_UNMASK: en_q   <= en_q | wd;
          default: ;
        endcase
      end
    end
  end

  assign clr_v = (wr_en && addr == A_CLR) ? wd : '0;

  for (genvar i = 0; i < 32; i++) begin : g_pin
    if (i < NP) begin : g_on
      gpio_edge_det u_det (
        .clk(clk), .rst_n(rst_n), .lvl(s2[i]), .act(mode_q[i]),
        .edge_mode(trig_q[i]), .pol(pol_q[i]), .both(both_q[i]),
        .clr(clr_v[i]), .stat(stat[i])
      );
    end else begin : g_off
      assign stat[i] = 1'b0;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q & ~mode_q;
  assign irq     = |(stat & en_q);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_MODE: rdata = mode_q;
        A_DIR:  rdata = dir_q;
        A_OUT:  rdata = out_q;
        A_IN:   rdata = (out_q & pin_oe) | (s2 & ~pin_oe);
        A_STAT: rdata = stat;
        A_MASK: rdata = en_q;
        A_POL:  rdata = pol_q;
        A_TRIG: rdata = trig_q;
        A_BOTH: rdata = both_q;
        A_PEND: rdata = stat & en_q;
        default: rdata = '0;
      endcase
    end
  end

  p_oe_io_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode_q) == '0);
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_OUT) |=> $stable(out_q));
  p_mask_only_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK) |=> (en_q & ~$past(en_q)) == '0);
  p_unmask_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_UNMASK) |=> (en_q & $past(wd)) == $past(wd));
  p_no_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  p_unused_pins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~VM) == '0);
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam logic [31:0] VM = 32'h00FF_FFFF;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe, rdata_w, pin_out_w, pin_oe_w;
  logic irq, irq_w;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] sh [0:19];

  always #2 clk = ~clk;

  gpio_bank #(.NPINS(24)) u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));
  gpio_bank #(.NPINS(0)) u_wide (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_w), .pin_in(pin_in), .pin_out(pin_out_w),
    .pin_oe(pin_oe_w), .irq(irq_w));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #0.5; d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] exp_oe();
    return sh[1] & ~sh[0];
  endfunction

  function automatic logic [31:0] exp_in(logic [31:0] p);
    return ((sh[2] & exp_oe()) | (p & ~exp_oe())) & VM;
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [4:0] wa [8] = '{5'd0, 5'd1, 5'd2, 5'd8, 5'd9, 5'd19, 5'd6, 5'd7};
    void'($urandom(32'd13));
    for (int i = 0; i < 20; i++) sh[i] = '0;
    wait_clk(3); @(negedge clk); rst_n = 1;

    // R1 reset state
    foreach (wa[i]) begin rd(wa[i], v); chk("R1 reset word", v, 32'h0); end
    @(negedge clk); chk("R1 oe", pin_oe, 0); chk("R1 irq", {31'b0, irq}, 0);

    // R2/R3/R5 random register traffic
    for (int i = 0; i < 60; i++) begin
      logic [4:0] a; logic [31:0] d;
      a = wa[$urandom % 8]; d = $urandom;
      wr(a, d);
      if (a == 5'd6) sh[6] = sh[6] & d & VM;
      else if (a == 5'd7) sh[6] = sh[6] | (d & VM);
      else sh[a] = d & VM;
      rd((a == 5'd7) ? 5'd6 : a, v);
      chk((a >= 5'd6 && a <= 5'd7) ? "R5 enable word" : "R2 readback", v,
          (a >= 5'd6 && a <= 5'd7) ? sh[6] : sh[a]);
      chk("R3 pin_oe", pin_oe, exp_oe());
      chk("R2 pin_out", pin_out, sh[2]);
    end
    rd(5'd7, v); chk("R5 unmask reads 0", v, 0);
    rd(5'd5, v); chk("R5 clear reads 0", v, 0);

    // R4 input readback with random directions and levels
    wr(5'd0, 0); sh[0] = 0;
    for (int i = 0; i < 20; i++) begin
      logic [31:0] p;
      sh[1] = $urandom & VM; sh[2] = $urandom & VM;
      wr(5'd1, sh[1]); wr(5'd2, sh[2]);
      p = $urandom; @(negedge clk); pin_in = p; wait_clk(3);
      rd(5'd3, v); chk("R4 input readback", v, exp_in(p));
    end
    wr(5'd1, 0); sh[1] = 0;

    // interrupt setup: pin0 rise, pin1 fall, pin2 both, pin3 level hi, pin4 level lo, pin6 io
    @(negedge clk); pin_in = 0;
    wr(5'd6, 0); wr(5'd8, 32'h12); wr(5'd9, 32'h07); wr(5'd19, 32'h04); wr(5'd0, 32'h1F);
    wait_clk(4); wr(5'd5, VM);
    rd(5'd4, v); chk("R8 level low active", v, 32'h10);
    @(negedge clk); pin_in = 32'h4F; wait_clk(4);
    rd(5'd4, v); chk("R6/R7/R8/R10 after rise", v, 32'h1D);
    @(negedge clk); pin_in = 32'h10; wait_clk(4);
    rd(5'd4, v); chk("R6 sticky, R7 fall, R8 drop", v, 32'h07);
    wr(5'd5, 32'h01);
    rd(5'd4, v); chk("R9 partial clear", v, 32'h06);

    // R11 enable / pending
    @(negedge clk); chk("R11 irq masked", {31'b0, irq}, 0);
    wr(5'd7, 32'h02);
    rd(5'd11, v); chk("R11 pending", v, 32'h02);
    @(negedge clk); chk("R11 irq on", {31'b0, irq}, 1);
    wr(5'd6, 32'hFFFF_FFFD);
    rd(5'd6, v); chk("R5 mask write", v, 0);
    @(negedge clk); chk("R11 irq off", {31'b0, irq}, 0);

    // R9 same-cycle: pin0 rising edge latches on the same edge as clear of bits 0 and 2
    @(negedge clk); pin_in = 32'h11;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1; addr = 5'd5; wdata = 32'h05;
    @(negedge clk); wr_en = 0;
    rd(5'd4, v); chk("R9 set beats clear", v, 32'h03);

    // R12 pin count limits
    wr(5'd1, 32'hFFFF_FFFF);
    @(negedge clk); rd_en = 1; addr = 5'd1; #0.5;
    chk("R12 narrow bank", rdata, VM);
    chk("R12 count 0 gives 32", rdata_w, 32'hFFFF_FFFF);
    @(negedge clk); rd_en = 0;
    chk("R12 oe upper", pin_oe & ~VM, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule